// File: doc/BRIEF.md
# Stretching Bidirectional Reset Generator

This block is the clocked core of a supply supervisor. It keeps a system in reset while the supply is low, while a secondary sense comparator reports its input below reference, or while a manual reset button is held. After the last of those causes goes away, it holds reset for one more programmed interval. It controls a shared open-drain reset line. It drives that line low through an output enable and also reads the line's level back.

Any other agent on the same line can start a reset by pulling the line low. The block sees the falling edge and drives the line itself for the full programmed interval, so a glitch-short pulse becomes a proper reset. If the other agent holds the line longer than the interval, the block lets go when its interval ends and leaves the line to that agent. Lows on the line that the block itself caused are never taken as new requests.

A 2-bit code selects one of four interval lengths, each given as a parameter. All asynchronous inputs pass through synchronizer chains. An active-high copy and a second active-low copy of the reset state are available as options.

Top module: `rsg_reset_stretcher`

## Requirements
- R1: While `rst_n` is low, `pin_drive_low` is 1. After `rst_n` is released, it stays 1 for exactly P(sel) clock cycles, counted from the first rising edge after release.
- R2: A supply-low level held for H cycles (H ≥ 1) gives exactly H+P−1 consecutive asserted cycles. Assertion starts on the third rising edge after the input rises, which covers two synchronizer flops plus the timer register.
- R3: After every hold cause clears, reset is released exactly P cycles after the last cycle in which the synchronized cause was seen. Release happens only when the interval counter has reached zero.
- R4: A falling edge on the sampled pin level, seen while the block is not driving, starts a drive of exactly P cycles. The drive begins on the third rising edge after the pin goes low.
- R5: An external low shorter than P is stretched, so the total drive is still P cycles.
- R6: An external low longer than P+3 cycles ends the drive after P cycles while the pin is still held low externally. Releasing that low afterwards does not start a new drive.
- R7: Manual reset (`mr_n_a` = 0) held for H cycles asserts reset in the same way as R2, for H+P−1 cycles.
- R8: A secondary sense low (`sense_low_a` = 1) held for H cycles asserts reset in the same way as R2, when sensing is enabled.
- R9: Pin lows that occur while the block is driving, or within SYNC_STAGES cycles after it stops, never start or extend a drive. Every drive start has a hold cause or an accepted falling edge behind it.
- R10: Code `sel` 0, 1, 2, 3 selects P = PER_0, PER_1, PER_2, PER_3. The code is taken on the cycle that loads the interval. A change of `sel` during a running interval does not change its length.
- R11: `rst_hi_o` is 1 exactly when reset is asserted, and `rst2_n_o` is its complement. An output disabled by parameter is held at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (power-on) |
| supply_low_a | input | 1 | Asynchronous supply-below-trip flag, 1 = low |
| sense_low_a | input | 1 | Asynchronous secondary comparator flag, 1 = below reference |
| mr_n_a | input | 1 | Asynchronous manual reset, active low |
| pin_level_a | input | 1 | Sampled level of the shared reset line, 0 = low |
| sel | input | 2 | Static interval selection code |
| pin_drive_low | output | 1 | Output enable; 1 pulls the reset line low |
| rst_hi_o | output | 1 | Active-high reset state |
| rst2_n_o | output | 1 | Second active-low reset state |

## Verification
A wrong count in the interval counter shows as a pulse that is too short or too long. It appears on `pin_drive_low` at the first release after the fault, which is at most P cycles away. A stale edge register or a missing guard window makes the block start again on its own driven low. That would appear as a second P-cycle drive within SYNC_STAGES+1 cycles of the first release. A code taken at the wrong moment shows as an interval length that matches the new code and not the old one, in the very pulse where the code changed.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   // bit positions inside the synchronized input vector
   localparam int unsigned IDX_SUPPLY = 0;
   localparam int unsigned IDX_SENSE  = 1;
   localparam int unsigned IDX_MR_N   = 2;
   localparam int unsigned IDX_PIN    = 3;
   localparam int unsigned N_ASYNC    = 4;

   // idle values loaded into the synchronizers during logic reset
   localparam logic [N_ASYNC-1:0] SYNC_IDLE = 4'b1100;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
   parameter int unsigned   W       = 4,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rsg_req_detect.sv
module rsg_req_detect #(
   parameter int unsigned GUARD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_low,
   input  logic driving,
   output logic trig
);
   logic             prev_low;
   logic [GUARD-1:0] drv_hist;
   logic             guard_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_low <= 1'b1;
         drv_hist <= '1;
      end else begin
         prev_low <= pin_low;
         drv_hist <= {drv_hist[GUARD-2:0], driving};
      end
   end

   // own drive reaches the sampled level late; block requests for that long
   assign guard_on = driving | (|drv_hist);
   assign trig     = pin_low & ~prev_low & ~guard_on;
endmodule

// File: rtl/rsg_timer.sv
module rsg_timer #(
   parameter int unsigned PER_0 = 4,
   parameter int unsigned PER_1 = 8,
   parameter int unsigned PER_2 = 16,
   parameter int unsigned PER_3 = 32,
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             trig,
   input  logic [1:0]       sel,
   output logic             active,
   output logic [CNT_W-1:0] cnt
);
   logic             load_pend;
   logic [CNT_W-1:0] reload;

   always_comb begin
      unique case (sel)
         2'd0:    reload = CNT_W'(PER_0 - 1);
         2'd1:    reload = CNT_W'(PER_1 - 1);
         2'd2:    reload = CNT_W'(PER_2 - 1);
         default: reload = CNT_W'(PER_3 - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b1;
         load_pend <= 1'b1;
         cnt       <= '0;
      end else if (hold || load_pend) begin
         active    <= 1'b1;
         load_pend <= 1'b0;
         cnt       <= reload;
      end else if (trig) begin
         active <= 1'b1;
         cnt    <= reload;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/rsg_reset_stretcher.sv
module rsg_reset_stretcher #(
   parameter int unsigned PER_0       = 1000,
   parameter int unsigned PER_1       = 5000,
   parameter int unsigned PER_2       = 20000,
   parameter int unsigned PER_3       = 100000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_SENSE   = 1'b1,
   parameter bit          USE_MANUAL  = 1'b1,
   parameter bit          HAS_HI_OUT  = 1'b1,
   parameter bit          HAS_SEC_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_low_a,
   input  logic       sense_low_a,
   input  logic       mr_n_a,
   input  logic       pin_level_a,
   input  logic [1:0] sel,
   output logic       pin_drive_low,
   output logic       rst_hi_o,
   output logic       rst2_n_o
);
   import rsg_pkg::*;

   localparam int unsigned PER_MAX = max4(PER_0, PER_1, PER_2, PER_3);
   localparam int unsigned CNT_W   = (PER_MAX > 2) ? $clog2(PER_MAX) : 1;

   if (PER_0 < 2 || PER_1 < 2 || PER_2 < 2 || PER_3 < 2) begin : g_bad_per
      $error("rsg_reset_stretcher: every interval must be at least 2 cycles");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rsg_reset_stretcher: SYNC_STAGES must be at least 2");
   end

   logic [N_ASYNC-1:0] raw_in, sync_q;
   logic               sense_hold, mr_hold, hold_s, ext_trig, active;
   logic [CNT_W-1:0]   tmr_cnt;

   assign raw_in[IDX_SUPPLY] = supply_low_a;
   assign raw_in[IDX_SENSE]  = sense_low_a;
   assign raw_in[IDX_MR_N]   = mr_n_a;
   assign raw_in[IDX_PIN]    = pin_level_a;

   rsg_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q));

   if (USE_SENSE) begin : g_sense
      assign sense_hold = sync_q[IDX_SENSE];
   end else begin : g_no_sense
      assign sense_hold = 1'b0;
   end

   if (USE_MANUAL) begin : g_manual
      assign mr_hold = ~sync_q[IDX_MR_N];
   end else begin : g_no_manual
      assign mr_hold = 1'b0;
   end

   assign hold_s = sync_q[IDX_SUPPLY] | sense_hold | mr_hold;

   rsg_req_detect #(.GUARD(SYNC_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .pin_low(~sync_q[IDX_PIN]),
      .driving(active), .trig(ext_trig));

   rsg_timer #(.PER_0(PER_0), .PER_1(PER_1), .PER_2(PER_2), .PER_3(PER_3),
               .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .hold(hold_s), .trig(ext_trig), .sel(sel),
      .active(active), .cnt(tmr_cnt));

   assign pin_drive_low = active;

   if (HAS_HI_OUT) begin : g_hi
      assign rst_hi_o = active;
   end else begin : g_no_hi
      assign rst_hi_o = 1'b0;
   end

   if (HAS_SEC_OUT) begin : g_sec
      assign rst2_n_o = ~active;
   end else begin : g_no_sec
      assign rst2_n_o = 1'b1;
   end
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned CNT_MAX = 100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold,
   input logic             trig,
   input logic             drive,
   input logic [CNT_W-1:0] cnt
);
   AST_HOLD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> drive);                                             // R2
   AST_EDGE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> drive);                                             // R4
   AST_RELEASE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive) |-> ($past(cnt) == '0 && !$past(hold)));        // R3
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (cnt <= CNT_W'(CNT_MAX)));                         // R10
   AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive) |-> ($past(hold) || $past(trig)));              // R9
endmodule

bind rsg_reset_stretcher rsg_checker #(.CNT_W(CNT_W), .CNT_MAX(PER_MAX - 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .hold(hold_s), .trig(ext_trig),
   .drive(pin_drive_low), .cnt(tmr_cnt));

// File: tb/sim_rsg_reset_stretcher.sv
module sim_rsg_reset_stretcher;
   localparam int CLK_PERIOD = 10;
   localparam int P0 = 5, P1 = 7, P2 = 11, P3 = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_low_a = 1'b0, sense_low_a = 1'b0, mr_n_a = 1'b1, ext_low = 1'b0;
   logic [1:0] sel = 2'd2;
   logic       pin_level_a, pin_drive_low, rst_hi_o, rst2_n_o;
   int         checks = 0, errors = 0, pol_bad = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // open-drain line: low if the block or the external agent pulls it
   assign pin_level_a = ~(pin_drive_low | ext_low);

   rsg_reset_stretcher #(.PER_0(P0), .PER_1(P1), .PER_2(P2), .PER_3(P3)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_low_a(supply_low_a), .sense_low_a(sense_low_a),
      .mr_n_a(mr_n_a), .pin_level_a(pin_level_a), .sel(sel),
      .pin_drive_low(pin_drive_low), .rst_hi_o(rst_hi_o), .rst2_n_o(rst2_n_o));

   function automatic int per(input int s);
      case (s)
         0: return P0;
         1: return P1;
         2: return P2;
         default: return P3;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (sel=%0d)", req, act, exp, sel);
      end
   endtask

   task automatic set_src(input int kind, input logic on);
      case (kind)
         0: supply_low_a = on;
         1: sense_low_a  = on;
         2: mr_n_a       = ~on;
         default: ext_low = on;
      endcase
   endtask

   // called right after a negedge; counts asserted samples over a window
   task automatic run(input int kind, input int len, input int win,
                      input int p2_at, input int p2_len, input int chg_at,
                      output int hi, output int tail);
      hi = 0; tail = 0;
      set_src(kind, 1'b1);
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (rst_hi_o !== pin_drive_low || rst2_n_o !== ~pin_drive_low) pol_bad++;
         if (pin_drive_low) hi++;
         if (i == len - 2) tail = pin_drive_low;
         if (i == len - 1) set_src(kind, 1'b0);
         if (i == p2_at) ext_low = 1'b1;
         if (p2_at >= 0 && i == p2_at + p2_len) ext_low = 1'b0;
         if (i == chg_at) sel = sel + 2'd1;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, tail, p;
      repeat (4) @(negedge clk);
      chk("R1 drive during reset", pin_drive_low, 1);
      chk("R11 second output during reset", rst2_n_o, 0);
      rst_n = 1'b1;
      hi = 0;
      for (int i = 0; i < P2 + 8; i++) begin
         @(negedge clk);
         if (pin_drive_low) hi++;
      end
      chk("R1 power-on interval", hi, P2);

      for (int s = 0; s < 4; s++) begin
         sel = 2'(s);
         p = per(s);
         repeat (3) @(negedge clk);
         foreach (hi_lens[k]) ;
         run(0, 1, p + 10, -1, 0, -1, hi, tail); chk("R2 supply H=1", hi, p);
         run(0, 3, p + 12, -1, 0, -1, hi, tail); chk("R3 supply H=3", hi, p + 2);
         run(0, 9, p + 18, -1, 0, -1, hi, tail); chk("R2 supply H=9", hi, p + 8);
         run(2, 4, p + 12, -1, 0, -1, hi, tail); chk("R7 manual H=4", hi, p + 3);
         run(1, 2, p + 10, -1, 0, -1, hi, tail); chk("R8 sense H=2", hi, p + 1);
         run(3, 1, p + 10, -1, 0, -1, hi, tail); chk("R4 edge start", hi, p);
         run(3, 3, p + 10, -1, 0, -1, hi, tail); chk("R5 short pulse stretched", hi, p);
         run(3, p + 6, 2 * p + 14, -1, 0, -1, hi, tail);
         chk("R6 long pulse drive length", hi, p);
         chk("R6 released while line held", tail, 0);
         run(3, 1, p + 12, 3, 2, -1, hi, tail); chk("R9 low while driving ignored", hi, p);
         run(3, 1, p + 10, -1, 0, 3, hi, tail); chk("R10 code change mid-interval", hi, p);
         sel = 2'(s);
      end
      chk("R11 output polarity mismatches", pol_bad, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   int hi_lens [1];
endmodule